// File: doc/BRIEF.md
# CPU Presence Bitmap Port with Legacy-to-Modern Mode Switch

This block keeps one presence flag per CPU, where the flag's bit position is the CPU's interrupt-controller ID. Firmware reads the flags one byte at a time over a small byte-wide bus with a 32-byte address window. When a CPU is hot-added, the block sets that CPU's flag. It also raises a pending event: a system-control interrupt line plus a general-purpose-event status vector with bit 2 set. The pending event stays raised until the event-status logic sends a clear pulse. Flags are never removed by any event. Only a power-on reset returns the map to its starting state, which is the boot CPU alone.

The bitmap cannot be changed from the bus, because ordinary writes are discarded. The one write pattern that has an effect is writing zero into all four bytes of the first 32-bit word. This pattern hands control to a newer register interface. The block shows that handover on a sticky mode output, and from then on it no longer answers bitmap reads.

Top module: `cpubm_legacy_port`

## Requirements
- R1: A read of byte address `a` returns, one cycle later with `rd_valid` high, a byte whose bit `k` is the presence flag of CPU ID `8*a+k`. Bit 0 is the lowest ID. Bits for IDs at or above `NUM_CPUS` read 0. `rd_data` is 0 whenever `rd_valid` is low.
- R2: A bus write never changes any presence flag.
- R3: Bit 0 of byte 0 (the boot CPU) always reads as 1.
- R4: A hot-add with ID below `NUM_CPUS` sets that CPU's flag. From the next cycle it drives `sci` high and `gpe_sts` to 8'h04 (bit 2 set). This holds in both modes.
- R5: A hot-add with ID at or above `NUM_CPUS` changes no flag and raises no event.
- R6: Presence flags are only ever set. A repeated hot-add of a present CPU leaves it present.
- R7: The pending event stays high until `evt_clear` is pulsed. When a valid hot-add and `evt_clear` arrive in the same cycle, the event stays pending.
- R8: Each of byte addresses 0..3 keeps a "zero seen" mark. A zero write to the byte sets its mark and a nonzero write clears it. Writes to bytes 4..31 do not touch the marks. On the edge where all four marks become set, `modern_mode` goes high. It stays high until power-on reset.
- R9: While `modern_mode` is high, reads are not serviced: `rd_valid` stays 0 and `rd_data` stays 0.
- R10: After reset, `modern_mode`, `sci`, `gpe_sts` and `rd_valid` are 0, and the map holds only the boot CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| hotadd_valid | input | 1 | Hot-add event strobe |
| hotadd_id | input | 8 | Interrupt-controller ID of the added CPU |
| evt_clear | input | 1 | Clear pulse from event-status logic |
| req_valid | input | 1 | Bus access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte address in the window |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data byte |
| sci | output | 1 | System-control interrupt line |
| gpe_sts | output | 8 | Event status, bit 2 = CPU hot-plug |
| modern_mode | output | 1 | High once the modern interface is active |

## Verification
Two things can happen in the same cycle: the event-status logic can clear the pending event while a new hot-add arrives. The bench forces this by driving `evt_clear` and a valid `hotadd_valid` on the same edge while an event is already pending. It then expects `sci` to remain high afterwards, because the new event must not be lost. A second, lone clear pulse must then drop `sci`, which shows that the first clear was overridden and not simply ignored.

// File: rtl/cpubm_pkg.sv
package cpubm_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic logic id_in_range(input int unsigned id, input int unsigned n);
    return id < n;
  endfunction

  function automatic int unsigned first_bit_of_byte(input int unsigned addr);
    return addr * BYTE_W;
  endfunction

  function automatic logic is_key_byte(input int unsigned addr, input int unsigned key_bytes);
    return addr < key_bytes;
  endfunction
endpackage

// File: rtl/cpubm_presence.sv
module cpubm_presence
  import cpubm_pkg::*;
#(
  parameter int unsigned NUM_CPUS  = 64,
  parameter int unsigned WIN_BYTES = 32,
  localparam int unsigned MAP_BITS = WIN_BYTES * BYTE_W,
  localparam int unsigned ID_W     = $clog2(MAP_BITS),
  localparam int unsigned ADDR_W   = $clog2(WIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_valid,
  input  logic [ID_W-1:0]   add_id,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              add_accept,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [NUM_CPUS-1:0] present_q;
  logic [MAP_BITS-1:0] padded;

  assign add_accept = add_valid && id_in_range(int'(add_id), NUM_CPUS);

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_bit
    localparam logic RESET_VAL = (i == 0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) present_q[i] <= RESET_VAL;
      else if (add_accept && (int'(add_id) == i)) present_q[i] <= 1'b1;
    end
  end

  assign padded  = MAP_BITS'(present_q);
  assign rd_byte = padded[first_bit_of_byte(int'(rd_addr)) +: BYTE_W];

  assert_boot_bit_R3: assert property (@(posedge clk) disable iff (!rst_n) present_q[0]);
  assert_never_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~present_q & $past(present_q)) == '0));
  assert_write_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && !add_valid) |=> $stable(present_q));
endmodule

// File: rtl/cpubm_mode_switch.sv
module cpubm_mode_switch
  import cpubm_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned KEY_BYTES = 4,
  localparam int unsigned ADDR_W   = $clog2(WIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              modern_o
);
  logic [KEY_BYTES-1:0] seen_q, seen_d;
  logic                 modern_q;
  logic                 key_complete;

  for (genvar j = 0; j < KEY_BYTES; j++) begin : g_lane
    logic lane_hit;
    assign lane_hit  = wr_fire && (int'(wr_addr) == j);
    assign seen_d[j] = lane_hit ? (wr_data == '0) : seen_q[j];
  end

  assign key_complete = &seen_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= '0;
      modern_q <= 1'b0;
    end else begin
      seen_q   <= seen_d;
      modern_q <= modern_q | key_complete;
    end
  end

  assign modern_o = modern_q;

  assert_sticky_mode_R8: assert property (@(posedge clk) disable iff (!rst_n) !$fell(modern_q));
  assert_rise_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modern_q) |-> $past(wr_fire && is_key_byte(int'(wr_addr), KEY_BYTES) && wr_data == '0));
endmodule

// File: rtl/cpubm_event.sv
module cpubm_event
  import cpubm_pkg::*;
#(
  parameter int unsigned GPE_W   = 8,
  parameter int unsigned GPE_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_accept,
  input  logic             evt_clear,
  output logic             sci_o,
  output logic [GPE_W-1:0] gpe_o
);
  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= add_accept | (pending_q & ~evt_clear);
  end

  assign sci_o = pending_q;
  assign gpe_o = GPE_W'(pending_q) << GPE_BIT;

  assert_hotadd_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    add_accept |=> (sci_o && gpe_o[GPE_BIT]));
  assert_hold_until_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !evt_clear) |=> pending_q);
endmodule

// File: rtl/cpubm_legacy_port.sv
module cpubm_legacy_port
  import cpubm_pkg::*;
#(
  parameter int unsigned NUM_CPUS  = 64,
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned KEY_BYTES = 4,
  localparam int unsigned ID_W     = $clog2(WIN_BYTES * BYTE_W),
  localparam int unsigned ADDR_W   = $clog2(WIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hotadd_valid,
  input  logic [ID_W-1:0]   hotadd_id,
  input  logic              evt_clear,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              sci,
  output logic [7:0]        gpe_sts,
  output logic              modern_mode
);
  logic              add_accept;
  logic [BYTE_W-1:0] map_byte;
  logic              wr_fire, rd_fire, bus_write;
  logic              rd_valid_q;
  logic [BYTE_W-1:0] rd_data_q;

  assign bus_write = req_valid && req_write;
  assign wr_fire   = bus_write && !modern_mode;
  assign rd_fire   = req_valid && !req_write && !modern_mode;

  cpubm_presence #(.NUM_CPUS(NUM_CPUS), .WIN_BYTES(WIN_BYTES)) u_map (
    .clk(clk), .rst_n(rst_n), .add_valid(hotadd_valid), .add_id(hotadd_id),
    .bus_write(bus_write), .rd_addr(req_addr), .add_accept(add_accept), .rd_byte(map_byte)
  );

  cpubm_mode_switch #(.WIN_BYTES(WIN_BYTES), .KEY_BYTES(KEY_BYTES)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(req_addr),
    .wr_data(req_wdata), .modern_o(modern_mode)
  );

  cpubm_event #(.GPE_W(8), .GPE_BIT(2)) u_evt (
    .clk(clk), .rst_n(rst_n), .add_accept(add_accept), .evt_clear(evt_clear),
    .sci_o(sci), .gpe_o(gpe_sts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_fire;
      rd_data_q  <= rd_fire ? map_byte : '0;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  assert_modern_gates_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    modern_mode |=> (!rd_valid && rd_data == '0));
  assert_idle_data_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));
  assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !modern_mode) |=> rd_valid);
endmodule

// File: tb/cpubm_legacy_port_test.sv
module cpubm_legacy_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 64;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       hotadd_valid = 0;
  logic [7:0] hotadd_id = 0;
  logic       evt_clear = 0;
  logic       req_valid = 0, req_write = 0;
  logic [4:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic       rd_valid, sci, modern_mode;
  logic [7:0] rd_data, gpe_sts;

  int errors = 0, checks = 0;
  logic [255:0] exp_map = 256'h1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpubm_legacy_port uut (
    .clk(clk), .rst_n(rst_n), .hotadd_valid(hotadd_valid), .hotadd_id(hotadd_id),
    .evt_clear(evt_clear), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .sci(sci), .gpe_sts(gpe_sts), .modern_mode(modern_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_read(input int a, output logic v, output logic [7:0] d);
    req_valid = 1; req_write = 0; req_addr = 5'(a);
    step();
    req_valid = 0;
    v = rd_valid; d = rd_data;
  endtask

  task automatic bus_write(input int a, input logic [7:0] d);
    req_valid = 1; req_write = 1; req_addr = 5'(a); req_wdata = d;
    step();
    req_valid = 0; req_write = 0;
  endtask

  task automatic hot_add(input int id, input logic clr);
    hotadd_valid = 1; hotadd_id = 8'(id); evt_clear = clr;
    step();
    hotadd_valid = 0; evt_clear = 0;
    if (id < NCPU) exp_map[id] = 1'b1;
  endtask

  task automatic pulse_clear();
    evt_clear = 1; step(); evt_clear = 0;
  endtask

  task automatic read_expect(input string req, input int a);
    logic v; logic [7:0] d;
    bus_read(a, v, d);
    check({req, " rd_valid"}, 32'(v), 1);
    check({req, " byte"}, 32'(d), 32'(exp_map[a*8 +: 8]));
  endtask

  task automatic t_reset();
    check("R10 modern", 32'(modern_mode), 0);
    check("R10 sci", 32'(sci), 0);
    check("R10 gpe", 32'(gpe_sts), 0);
    check("R10 rd_valid", 32'(rd_valid), 0);
    check("R1 idle data", 32'(rd_data), 0);
    read_expect("R3 boot bit", 0);
    read_expect("R10 byte1", 1);
  endtask

  task automatic t_hotadd();
    hot_add(9, 0);
    check("R4 sci", 32'(sci), 1);
    check("R4 gpe", 32'(gpe_sts), 32'h04);
    read_expect("R4 byte1", 1);
    hot_add(63, 0);
    read_expect("R1 top id", 7);
    read_expect("R1 beyond cpus", 31);
    hot_add(9, 0);
    read_expect("R6 repeat", 1);
    pulse_clear();
    check("R7 cleared", 32'(sci), 0);
  endtask

  task automatic t_out_of_range();
    hot_add(64, 0);
    check("R5 no sci", 32'(sci), 0);
    read_expect("R5 byte8", 8);
    hot_add(200, 0);
    check("R5 no gpe", 32'(gpe_sts), 0);
    read_expect("R5 byte25", 25);
  endtask

  task automatic t_collision();
    hot_add(5, 0);
    step(); step();
    check("R7 held", 32'(sci), 1);
    hot_add(6, 1);
    check("R7 set wins", 32'(sci), 1);
    pulse_clear();
    check("R7 lone clear", 32'(sci), 0);
    read_expect("R6 byte0", 0);
  endtask

  task automatic t_writes();
    bus_write(0, 8'hFE);
    bus_write(1, 8'h00);
    bus_write(7, 8'hFF);
    read_expect("R2 byte0", 0);
    read_expect("R2 byte1", 1);
    read_expect("R2 byte7", 7);
    check("R8 no switch", 32'(modern_mode), 0);
  endtask

  task automatic t_mode();
    logic v; logic [7:0] d;
    bus_write(0, 0); bus_write(1, 0); bus_write(2, 8'h55); bus_write(3, 0);
    check("R8 nonzero byte", 32'(modern_mode), 0);
    bus_write(4, 0);
    check("R8 byte4 ignored", 32'(modern_mode), 0);
    bus_write(1, 8'h01); bus_write(2, 0);
    check("R8 withdrawn", 32'(modern_mode), 0);
    read_expect("R1 still legacy", 0);
    bus_write(1, 0);
    check("R8 switched", 32'(modern_mode), 1);
    bus_read(0, v, d);
    check("R9 no valid", 32'(v), 0);
    check("R9 zero data", 32'(d), 0);
    bus_write(0, 8'hFF);
    check("R8 sticky", 32'(modern_mode), 1);
    hot_add(12, 0);
    check("R4 modern sci", 32'(sci), 1);
    pulse_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hotadd();
    t_out_of_range();
    t_collision();
    t_writes();
    t_mode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule